// File: doc/BRIEF.md
# Stereo Serial Audio Receiver with Zero Detect

This block takes a two-channel serial audio stream on three wires: a frame clock that selects the channel, a bit clock, and a data line. It runs on a fast system clock and samples all three. It rebuilds a left and a right two's-complement sample of 16, 20 or 24 bits and sign-extends each one to 24 bits. Each completed stereo pair is presented with a one-cycle valid strobe.

The bit clock may arrive in gated bursts. For that reason, slot boundaries come only from frame clock transitions, and bits are counted only on the bit clock rising edges that actually occur.

The block also watches the received pairs. It raises a zero flag once more than 1024 consecutive stereo frames have been all-zero on both channels. A frame that carries any nonzero sample drops the flag at once.

Top module: `stereo_rx`

## Requirements
- R1: Frame clock low marks the left slot and high marks the right slot. Each slot starts at a frame clock transition. The first bit clock rising edge in a slot carries no data, and the MSB is taken on the second rising edge.
- R2: `word_len` selects the sample length: 2'b00 gives 16 bits, 2'b01 gives 20 bits, and 2'b10 or 2'b11 gives 24 bits. It must be held stable across a frame.
- R3: Words shorter than 24 bits are sign-extended to 24 bits from their own MSB on `left_out` and `right_out`.
- R4: Bits that arrive in a slot after the selected word length has been received have no effect on the output sample.
- R5: The bit clock may stop for any number of system clocks between rising edges, and samples still assemble correctly. A slot with no bit clock edges yields a zero sample.
- R6: `valid` pulses for exactly one cycle per stereo frame, when the right slot ends (the frame clock falls). It does not pulse at the end of a left slot. `left_out` and `right_out` show the new pair in the same cycle.
- R7: `left_out` and `right_out` hold their values in every cycle in which `valid` is low.
- R8: `zero_flag` rises, together with `valid`, at the end of the 1025th consecutive frame whose left and right samples are both zero. It stays low through the 1024th such frame.
- R9: A completed frame with any nonzero sample clears `zero_flag` in its `valid` cycle and restarts the run count.
- R10: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_clk | input | 1 | Channel select: low for left, high for right |
| bit_clk | input | 1 | Serial bit clock, data sampled on its rising edge; may be gated |
| sdata | input | 1 | Serial data, MSB first |
| word_len | input | 2 | Word length select (16/20/24) |
| left_out | output | 24 | Sign-extended left sample |
| right_out | output | 24 | Sign-extended right sample |
| valid | output | 1 | One-cycle strobe for a new stereo pair |
| zero_flag | output | 1 | High after a sustained all-zero run |

## Verification
The assertions assume three things about the inputs. First, the frame clock and the bit clock are synchronous to the system clock. Second, a bit clock rising edge never falls in the same system cycle as a frame clock transition. Third, `word_len` changes only at the start of a frame, after the previous pair has completed. The stimulus drives every input on the falling system clock edge and changes the frame clock only while the bit clock stays level. It inserts random idle gaps between bit clock pulses and updates the word length only right after checking the `valid` cycle at a frame start.

// File: rtl/stereo_rx.sv
module stereo_rx #(
  parameter int ZERO_RUN = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_clk,
  input  logic        bit_clk,
  input  logic        sdata,
  input  logic [1:0]  word_len,
  output logic [23:0] left_out,
  output logic [23:0] right_out,
  output logic        valid,
  output logic        zero_flag
);
  localparam int RUNW = $clog2(ZERO_RUN + 2);
  localparam logic [RUNW-1:0] RUN_MAX = RUNW'(ZERO_RUN + 1);

  logic            lr_q, bclk_q;
  logic [4:0]      cnt;
  logic [23:0]     shreg, left_hold, word;
  logic [4:0]      nbits;
  logic [RUNW-1:0] run;

  wire lr_edge = frame_clk ^ lr_q;
  wire brise   = bit_clk & ~bclk_q;
  wire take    = (cnt != 5'd0) && (cnt <= nbits);
  wire both_zero = (left_hold == 24'd0) && (word == 24'd0);

  always_comb begin
    case (word_len)
      2'b00:   begin nbits = 5'd16; word = {{8{shreg[15]}}, shreg[15:0]}; end
      2'b01:   begin nbits = 5'd20; word = {{4{shreg[19]}}, shreg[19:0]}; end
      default: begin nbits = 5'd24; word = shreg; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lr_q   <= 1'b0;
      bclk_q <= 1'b0;
      cnt    <= '0;
      shreg  <= '0;
    end else begin
      lr_q   <= frame_clk;
      bclk_q <= bit_clk;
      if (lr_edge) begin
        cnt   <= '0;
        shreg <= '0;
      end else if (brise) begin
        if (cnt != 5'd31) cnt <= cnt + 5'd1;
        if (take) shreg <= {shreg[22:0], sdata};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_hold <= '0;
      left_out  <= '0;
      right_out <= '0;
      valid     <= 1'b0;
      zero_flag <= 1'b0;
      run       <= '0;
    end else begin
      valid <= 1'b0;
      if (lr_edge && !lr_q) left_hold <= word;
      if (lr_edge && lr_q) begin
        left_out  <= left_hold;
        right_out <= word;
        valid     <= 1'b1;
        if (both_zero) begin
          if (run != RUN_MAX) run <= run + 1'b1;
          zero_flag <= (run >= RUNW'(ZERO_RUN));
        end else begin
          run       <= '0;
          zero_flag <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/stereo_rx_chk.sv
module stereo_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_clk,
  input logic        lr_q,
  input logic [1:0]  word_len,
  input logic [23:0] left_out,
  input logic [23:0] right_out,
  input logic        valid,
  input logic        zero_flag
);
  AST_VALID_AFTER_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ($past(lr_q) && !$past(frame_clk))); // R6
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid); // R6
  AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> ($stable(left_out) && $stable(right_out))); // R7
  AST_SIGN_EXT16: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && $past(word_len) == 2'b00) |->
      ((left_out[23:16] == {8{left_out[15]}}) && (right_out[23:16] == {8{right_out[15]}}))); // R3
  AST_FLAG_ONLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    zero_flag |-> (left_out == 24'd0 && right_out == 24'd0)); // R9
  AST_FLAG_RISES_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zero_flag) |-> valid); // R8
  AST_RESET_STATE: assert property (@(posedge clk)
    $past(!rst_n) |-> (!valid && !zero_flag && left_out == 24'd0)); // R10
endmodule

bind stereo_rx stereo_rx_chk chk (
  .clk(clk), .rst_n(rst_n), .frame_clk(frame_clk), .lr_q(lr_q),
  .word_len(word_len), .left_out(left_out), .right_out(right_out),
  .valid(valid), .zero_flag(zero_flag)
);

// File: tb/stereo_rx_test.sv
`timescale 1ns/1ps
module stereo_rx_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_clk = 1'b0, bit_clk = 1'b0, sdata = 1'b0;
  logic [1:0] word_len = 2'b10;
  logic [23:0] left_out, right_out;
  logic valid, zero_flag;

  int checks = 0, fails = 0;
  logic [23:0] prev_l = '0, prev_r = '0;
  logic have_prev = 1'b0;
  logic [1:0] prev_wl = 2'b10;
  int run = 0;

  always #2.5 clk = ~clk;

  stereo_rx uut (.clk(clk), .rst_n(rst_n), .frame_clk(frame_clk), .bit_clk(bit_clk),
    .sdata(sdata), .word_len(word_len), .left_out(left_out), .right_out(right_out),
    .valid(valid), .zero_flag(zero_flag));

  function automatic int nb(input logic [1:0] wl);
    return (wl == 2'b00) ? 16 : (wl == 2'b01) ? 20 : 24;
  endfunction

  function automatic logic [23:0] sx(input logic [23:0] v, input logic [1:0] wl);
    if (wl == 2'b00) return {{8{v[15]}}, v[15:0]};
    if (wl == 2'b01) return {{4{v[19]}}, v[19:0]};
    return v;
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    sdata = b; bit_clk = 1'b0;
    repeat (1 + ($urandom % 3)) @(negedge clk);
    bit_clk = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_slot(input logic [23:0] v, input int n, input int extra);
    send_bit($urandom % 2);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    for (int i = 0; i < extra; i++) send_bit($urandom % 2);
  endtask

  task automatic check_completion();
    if (have_prev) begin
      check(valid === 1'b1, "R6 valid at right end", valid, 1);
      check(left_out === sx(prev_l, prev_wl), "R1/R3 left", left_out, sx(prev_l, prev_wl));
      check(right_out === sx(prev_r, prev_wl), "R1/R3 right", right_out, sx(prev_r, prev_wl));
      if (sx(prev_l, prev_wl) == 0 && sx(prev_r, prev_wl) == 0) run++; else run = 0;
      check(zero_flag === (run > 1024), "R8/R9 zero flag", zero_flag, run > 1024);
    end
  endtask

  task automatic frame(input logic [23:0] l, input logic [23:0] r, input logic [1:0] wl,
                       input logic fast, input int extra);
    logic [23:0] hold;
    frame_clk = 1'b0;
    @(negedge clk);
    check_completion();
    @(negedge clk);
    check(valid === 1'b0, "R6 single pulse", valid, 0);
    hold = left_out;
    word_len = wl;
    if (!fast) send_slot(l, nb(wl), extra); else @(negedge clk);
    frame_clk = 1'b1;
    @(negedge clk);
    check(valid === 1'b0, "R6 no pulse after left", valid, 0);
    check(left_out === hold, "R7 hold", left_out, hold);
    if (!fast) send_slot(r, nb(wl), extra); else @(negedge clk);
    prev_l = fast ? 24'd0 : l;
    prev_r = fast ? 24'd0 : r;
    prev_wl = wl;
    have_prev = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    check(left_out === 0 && right_out === 0, "R10 reset data", left_out, 0);
    check(valid === 0 && zero_flag === 0, "R10 reset flags", {valid, zero_flag}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed: R2 encodings, R3 sign, R4 extra bits
    frame(24'h00_8001, 24'h00_7FFF, 2'b00, 1'b0, 3);
    frame(24'h08_0000, 24'h07_FFFF, 2'b01, 1'b0, 2);
    frame(24'h80_0000, 24'h7F_FFFF, 2'b10, 1'b0, 0);
    frame(24'hA5_5A5A, 24'h12_3456, 2'b11, 1'b0, 4);
    // R5: a slot with no bit clock gives zero
    frame(24'h0, 24'h0, 2'b10, 1'b1, 0);
    // random frames
    for (int k = 0; k < 40; k++)
      frame($urandom, $urandom, 2'($urandom % 4), 1'b0, $urandom % 4);
    // R8: a long all-zero run with gated (absent) bit clock
    for (int k = 0; k < 1030; k++) frame(24'h0, 24'h0, 2'b00, 1'b1, 0);
    // R9: a nonzero frame clears the flag
    frame(24'h0, 24'h00_0001, 2'b10, 1'b0, 0);
    frame(24'h0, 24'h0, 2'b10, 1'b1, 0);
    frame(24'h0, 24'h0, 2'b10, 1'b1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R6 actual=hang expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule